// File: doc/BRIEF.md
# Mechanism End-Stop Detector

The block decides whether a sled or a stepper mechanism has run into its mechanical end stop. The only moment at which the back-EMF of the moving part can be read cleanly is when its drive command passes through zero, so the detector watches the signed sled command and marks each zero crossing. It then takes the next digitised back-EMF magnitude from an external converter and compares it with a threshold picked by a 2-bit code from one of two tables, one for each target. A reading below the threshold means the mechanism has stopped against its end, and the status flag is raised.

The flag holds until a later evaluated reading rises above the threshold again. Software enables the detector, selects the target (sled or stepper) and picks the threshold code. Code 0 turns detection off. All thresholds are parameters in converter LSB units. With the default parameters, one LSB is 1 mV. The sled table then holds 22, 46 and 86 and the stepper table holds 19, 39 and 60.

Top module: `endstop_detector`

## Requirements
- R1: While `det_en` is 0, `end_flag` is 0 after the next clock edge and no pending crossing is kept. A crossing seen while disabled is never evaluated after `det_en` returns to 1.
- R2: `tgt_sel` = 0 selects the sled table and `tgt_sel` = 1 the stepper table. For the codes `th_sel` = 1, 2, 3, the defaults are 22, 46, 86 (sled) and 19, 39, 60 (stepper), in LSB.
- R3: With `th_sel` = 0, detection is off: `end_flag` is 0 after the next clock edge and no pending crossing is kept.
- R4: A command is in the dead band when |cmd| <= DEADBAND (default 51). Otherwise it is positive or negative by its sign. Each `cmd_vld` forms a crossing if the previous command was outside the dead band and the new one lies in a different region. That covers positive to negative, negative to positive, and either one into the dead band. Leaving the dead band, or staying in one region, is no crossing. Before the first command, the previous region is the dead band.
- R5: Only the first `bemf_vld` sample at a clock edge strictly after the edge that registered a crossing is evaluated. A sample given in the same cycle as the crossing, or with no crossing pending, has no effect on `end_flag`.
- R6: An evaluated sample strictly below the selected threshold sets `end_flag` to 1.
- R7: An evaluated sample strictly above the threshold clears `end_flag` to 0. A sample equal to the threshold leaves it unchanged.
- R8: `end_flag` changes at the clock edge that takes the evaluated sample. It holds its value in cycles without an evaluation.
- R9: After synchronous reset, `end_flag` is 0 and no crossing is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Detector enable |
| tgt_sel | input | 1 | Target: 0 sled, 1 stepper |
| th_sel | input | 2 | Threshold code, 0 = off |
| cmd | input | CMD_W (12) | Signed sled drive command |
| cmd_vld | input | 1 | New command strobe |
| bemf | input | BEMF_W (10) | Unsigned back-EMF magnitude sample |
| bemf_vld | input | 1 | Back-EMF sample strobe |
| end_flag | output | 1 | End-stop detected status |

## Verification
The assertions assume that `tgt_sel` and `th_sel` are stable around an evaluation, so that the threshold sampled by the flag logic is the one the properties compare against. They also assume that all strobes are clean single-cycle pulses. The bench changes configuration only between transactions, in cycles with no strobe, and drives every strobe for exactly one cycle away from the active edge. It also clears the detector by toggling the enable, so that each swept case starts with no pending crossing and the flag at 0.

// File: rtl/endstop_pkg.sv
package endstop_pkg;

    typedef enum logic [1:0] {
        REG_DEAD = 2'd0,
        REG_POS  = 2'd1,
        REG_NEG  = 2'd2
    } cmd_region_e;

    typedef enum logic {
        TGT_SLED = 1'b0,
        TGT_STEP = 1'b1
    } target_e;

    typedef struct packed {
        logic armed;
        logic flag;
    } det_state_t;

    function automatic cmd_region_e classify(input int value, input int band);
        if (value > band)       return REG_POS;
        else if (value < -band) return REG_NEG;
        else                    return REG_DEAD;
    endfunction

    function automatic logic is_crossing(input cmd_region_e prev, input cmd_region_e cur);
        return (prev != REG_DEAD) && (cur != prev);
    endfunction

endpackage

// File: rtl/endstop_zero_cross.sv
module endstop_zero_cross
    import endstop_pkg::*;
#(
    parameter int CMD_W    = 12,
    parameter int DEADBAND = 51
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_vld,
    input  logic signed [CMD_W-1:0] cmd,
    output logic                    xing
);

    cmd_region_e prev_region;
    cmd_region_e cur_region;

    always_comb begin
        cur_region = classify(int'(cmd), DEADBAND);
        xing       = cmd_vld && is_crossing(prev_region, cur_region);
    end

    always_ff @(posedge clk) begin
        if (rst)          prev_region <= REG_DEAD;
        else if (cmd_vld) prev_region <= cur_region;
    end

    // R4: the remembered region only moves on a new command
    assert_region_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cmd_vld |=> $stable(prev_region));

    // R4: no crossing can come out of the dead band
    assert_no_xing_from_dead_R4: assert property (@(posedge clk) disable iff (rst)
        (prev_region == REG_DEAD) |-> !xing);

endmodule

// File: rtl/endstop_thresh.sv
module endstop_thresh
    import endstop_pkg::*;
#(
    parameter int                BEMF_W   = 10,
    parameter logic [BEMF_W-1:0] SLED_TH1 = BEMF_W'(22),
    parameter logic [BEMF_W-1:0] SLED_TH2 = BEMF_W'(46),
    parameter logic [BEMF_W-1:0] SLED_TH3 = BEMF_W'(86),
    parameter logic [BEMF_W-1:0] STEP_TH1 = BEMF_W'(19),
    parameter logic [BEMF_W-1:0] STEP_TH2 = BEMF_W'(39),
    parameter logic [BEMF_W-1:0] STEP_TH3 = BEMF_W'(60)
) (
    input  logic              tgt_sel,
    input  logic [1:0]        th_sel,
    output logic [BEMF_W-1:0] thr,
    output logic              active
);

    localparam int NTGT  = 2;
    localparam int NCODE = 4;

    logic [BEMF_W-1:0] tbl [NTGT][NCODE];

    for (genvar t = 0; t < NTGT; t++) begin : g_tbl
        if (t == int'(TGT_SLED)) begin : g_sled
            assign tbl[t][0] = '0;
            assign tbl[t][1] = SLED_TH1;
            assign tbl[t][2] = SLED_TH2;
            assign tbl[t][3] = SLED_TH3;
        end else begin : g_step
            assign tbl[t][0] = '0;
            assign tbl[t][1] = STEP_TH1;
            assign tbl[t][2] = STEP_TH2;
            assign tbl[t][3] = STEP_TH3;
        end
    end

    always_comb begin
        thr    = tbl[tgt_sel][th_sel];
        active = (th_sel != 2'd0);
    end

endmodule

// File: rtl/endstop_detector.sv
module endstop_detector
    import endstop_pkg::*;
#(
    parameter int                CMD_W    = 12,
    parameter int                DEADBAND = 51,
    parameter int                BEMF_W   = 10,
    parameter logic [BEMF_W-1:0] SLED_TH1 = BEMF_W'(22),
    parameter logic [BEMF_W-1:0] SLED_TH2 = BEMF_W'(46),
    parameter logic [BEMF_W-1:0] SLED_TH3 = BEMF_W'(86),
    parameter logic [BEMF_W-1:0] STEP_TH1 = BEMF_W'(19),
    parameter logic [BEMF_W-1:0] STEP_TH2 = BEMF_W'(39),
    parameter logic [BEMF_W-1:0] STEP_TH3 = BEMF_W'(60)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    det_en,
    input  logic                    tgt_sel,
    input  logic [1:0]              th_sel,
    input  logic signed [CMD_W-1:0] cmd,
    input  logic                    cmd_vld,
    input  logic [BEMF_W-1:0]       bemf,
    input  logic                    bemf_vld,
    output logic                    end_flag
);

    logic              xing;
    logic [BEMF_W-1:0] thr;
    logic              active;
    det_state_t        st;

    endstop_zero_cross #(
        .CMD_W    (CMD_W),
        .DEADBAND (DEADBAND)
    ) u_zc (
        .clk     (clk),
        .rst     (rst),
        .cmd_vld (cmd_vld),
        .cmd     (cmd),
        .xing    (xing)
    );

    endstop_thresh #(
        .BEMF_W   (BEMF_W),
        .SLED_TH1 (SLED_TH1),
        .SLED_TH2 (SLED_TH2),
        .SLED_TH3 (SLED_TH3),
        .STEP_TH1 (STEP_TH1),
        .STEP_TH2 (STEP_TH2),
        .STEP_TH3 (STEP_TH3)
    ) u_thr (
        .tgt_sel (tgt_sel),
        .th_sel  (th_sel),
        .thr     (thr),
        .active  (active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (!det_en || !active) begin
            st <= '0;
        end else begin
            if (st.armed && bemf_vld) begin
                st.armed <= 1'b0;
                if (bemf < thr)      st.flag <= 1'b1;
                else if (bemf > thr) st.flag <= 1'b0;
            end
            if (xing) st.armed <= 1'b1;
        end
    end

    assign end_flag = st.flag;

    // R1: disabling forces the flag low
    assert_disable_clears_R1: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> !end_flag);

    // R3: threshold code 0 forces the flag low
    assert_code0_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (th_sel == 2'd0) |=> !end_flag);

    // R6: a rising flag needs a low back-EMF sample in the previous cycle
    assert_rise_on_low_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(end_flag) |-> ($past(bemf_vld) && ($past(bemf) < $past(thr))));

    // R7: a falling flag while enabled needs a high sample
    assert_fall_on_high_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(end_flag) && $past(det_en) && $past(active))
            |-> ($past(bemf_vld) && ($past(bemf) > $past(thr))));

    // R8: the flag holds when no sample arrives
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!bemf_vld && det_en && active) |=> $stable(end_flag));

endmodule

// File: tb/tb_endstop_detector.sv
module tb_endstop_detector;

    localparam int CLK_PERIOD = 10;
    localparam int CMD_W      = 12;
    localparam int BEMF_W     = 10;
    localparam int DB         = 51;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    det_en = 1'b0;
    logic                    tgt_sel = 1'b0;
    logic [1:0]              th_sel = 2'd1;
    logic signed [CMD_W-1:0] cmd = '0;
    logic                    cmd_vld = 1'b0;
    logic [BEMF_W-1:0]       bemf = '0;
    logic                    bemf_vld = 1'b0;
    logic                    end_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    endstop_detector dut (
        .clk      (clk),
        .rst      (rst),
        .det_en   (det_en),
        .tgt_sel  (tgt_sel),
        .th_sel   (th_sel),
        .cmd      (cmd),
        .cmd_vld  (cmd_vld),
        .bemf     (bemf),
        .bemf_vld (bemf_vld),
        .end_flag (end_flag)
    );

    function automatic int thr_of(input int t, input int s);
        int sled [4] = '{0, 22, 46, 86};
        int step [4] = '{0, 19, 39, 60};
        return (t == 0) ? sled[s] : step[s];
    endfunction

    function automatic int region(input int v);
        if (v > DB)  return 1;
        if (v < -DB) return 2;
        return 0;
    endfunction

    task automatic chk(input logic exp, input string req);
        checks++;
        if (end_flag !== exp) begin
            errors++;
            $display("FAIL %s end_flag actual %0b expected %0b", req, end_flag, exp);
        end
    endtask

    task automatic send_cmd(input int v);
        @(negedge clk); cmd = CMD_W'(v); cmd_vld = 1'b1;
        @(negedge clk); cmd_vld = 1'b0;
    endtask

    task automatic send_bemf(input int v);
        @(negedge clk); bemf = BEMF_W'(v); bemf_vld = 1'b1;
        @(negedge clk); bemf_vld = 1'b0;
    endtask

    task automatic send_both(input int c, input int b);
        @(negedge clk); cmd = CMD_W'(c); cmd_vld = 1'b1; bemf = BEMF_W'(b); bemf_vld = 1'b1;
        @(negedge clk); cmd_vld = 1'b0; bemf_vld = 1'b0;
    endtask

    task automatic clear_det();
        @(negedge clk); det_en = 1'b0;
        @(negedge clk); det_en = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int vals [7] = '{-2048, -52, -51, 0, 51, 52, 2047};
        repeat (3) @(negedge clk);
        chk(1'b0, "R9 reset");
        rst = 1'b0;
        det_en = 1'b1;
        @(negedge clk);
        chk(1'b0, "R9 after reset");

        // R2 R6 R7 sweep over both tables and all nonzero codes
        for (int t = 0; t < 2; t++) begin
            for (int s = 1; s < 4; s++) begin
                int th;
                th = thr_of(t, s);
                tgt_sel = t[0];
                th_sel = s[1:0];
                clear_det();
                send_cmd(200); send_cmd(-200);
                send_bemf(th - 1); chk(1'b1, "R6 R2 below threshold sets");
                send_cmd(200);
                send_bemf(th);     chk(1'b1, "R7 equal keeps set");
                send_cmd(-200);
                send_bemf(th + 1); chk(1'b0, "R7 R2 above threshold clears");
                send_cmd(200);
                send_bemf(th);     chk(1'b0, "R7 equal keeps clear");
            end
        end

        // R5 gating of samples
        tgt_sel = 1'b0; th_sel = 2'd1;
        clear_det();
        send_bemf(0); chk(1'b0, "R5 sample without crossing ignored");
        send_cmd(-200); send_bemf(500); chk(1'b0, "R5 arm consumed");
        send_both(200, 0); chk(1'b0, "R5 same-cycle sample ignored");
        send_bemf(0); chk(1'b1, "R5 next sample evaluated");
        send_bemf(500); chk(1'b1, "R5 second sample ignored");

        // R8 hold while idle
        repeat (5) @(negedge clk);
        chk(1'b1, "R8 flag held idle");

        // R1 enable
        @(negedge clk); det_en = 1'b0;
        @(negedge clk); chk(1'b0, "R1 disable clears flag");
        det_en = 1'b1;
        send_bemf(0); chk(1'b0, "R1 nothing pending after disable");
        det_en = 1'b0;
        send_cmd(-200);
        @(negedge clk); det_en = 1'b1;
        send_bemf(0); chk(1'b0, "R1 crossing while disabled not armed");

        // R3 code zero
        send_cmd(200); send_bemf(0); chk(1'b1, "R3 setup flag set");
        @(negedge clk); th_sel = 2'd0;
        @(negedge clk); chk(1'b0, "R3 code 0 clears flag");
        th_sel = 2'd1;
        send_bemf(0); chk(1'b0, "R3 nothing pending after code 0");

        // R4 crossing table over command pairs
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                logic exp;
                int ra, rb;
                ra = region(vals[i]);
                rb = region(vals[j]);
                exp = (ra != 0) && (rb != ra);
                clear_det();
                send_cmd(vals[i]);
                send_bemf(500);
                send_cmd(vals[j]);
                send_bemf(0);
                checks++;
                if (end_flag !== exp) begin
                    errors++;
                    $display("FAIL R4 pair %0d->%0d end_flag actual %0b expected %0b",
                             vals[i], vals[j], end_flag, exp);
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule